// File: doc/BRIEF.md
# LCD Sync Timing Generator

This block runs on the pixel clock of a small LCD and produces horizontal sync, vertical sync and data-enable strobes. It also produces the pixel column and row of the current clock and a polarity-inversion toggle for the panel drive. A 4-bit format code picks one of four built-in timing profiles. Each profile gives, for each axis, the lengths of the active, front porch, sync and back porch regions, in that order.

Static configuration inputs set the timing behaviour. They set the active level of each strobe and which strobes are emitted. They set the scan direction of each coordinate and whether the inversion output toggles per line or per frame. The format code is applied only at a frame boundary. The other inputs act at once. Pixel data and scaling are handled elsewhere.

Top module: `lcd_sync_gen`

## Requirements
- R1: While rst_ni is low the counters and the inversion output are cleared. Every emitted strobe sits at its inactive level and both coordinates are 0.
- R2: fmt_code_i selects a profile. Codes 0 to 3 select the serial profile (320 active, 359 front, 1 sync, 241 back clocks; 240 active, 4 front, 1 sync, 17 back lines). Codes 5 and 6 select the parallel profile (320/38/1/50; 240/4/1/17). Codes 7 and 8 select the YUV profile (640/252/1/28; 320/4/1/18). Codes 10 and 11 select the stream profile (640/3/1/272; 480/4/1/15). Each axis counts active, then front porch, then sync, then back porch.
- R3: hsync_o is active for the sync clocks of every line. Its active level is high when sync_pol_i[0] is 1 and low when it is 0.
- R4: vsync_o is active for every clock of the sync lines. Its active level is set by sync_pol_i[1] in the same way.
- R5: de_o is active when both axes are in their active region. Its active level is high when sync_pol_i[2] is 1.
- R6: sync_mode_i selects which strobes are emitted: 0 emits both syncs, 1 emits both syncs and data enable, 2 emits data enable only, and 3 emits none. A strobe that is not emitted stays at its inactive level.
- R7: x_o is the column during active clocks: the count itself when scan_dir_i[0] is 1, mirrored (active width − 1 − count) when it is 0. x_o is 0 outside the active region.
- R8: y_o is the row during active clocks, mirrored by scan_dir_i[1] in the same way, and is 0 outside the active region.
- R9: inv_o toggles after the last clock of every line when line_inv_i is 1, and after the last clock of every frame when line_inv_i is 0.
- R10: Codes 4, 9 and 12 to 15 are idle formats. They hold the strobes inactive, the coordinates at 0, inv_o at 0 and the counters at 0. A valid code then starts a frame on the next clock.
- R11: A format code change while running takes effect only at the first clock after the current frame ends. No partial frame is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | pixel clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| fmt_code_i | input | 4 | format code |
| scan_dir_i | input | 2 | bit 0 column direction, bit 1 row direction (1 = forward) |
| sync_pol_i | input | 3 | active-high select: bit 0 hsync, bit 1 vsync, bit 2 data enable |
| sync_mode_i | input | 2 | strobe emission mode |
| line_inv_i | input | 1 | 1 = invert per line, 0 = per frame |
| hsync_o | output | 1 | horizontal sync |
| vsync_o | output | 1 | vertical sync |
| de_o | output | 1 | data enable |
| inv_o | output | 1 | polarity-inversion toggle |
| x_o | output | 11 | pixel column |
| y_o | output | 11 | pixel row |

## Verification
The assertions check on every cycle that the counters stay inside the selected frame. They check that the profile changes only at position zero, that the inversion output changes only at a line or frame start, and that an idle format keeps the coordinates and inversion output cleared. They also check that hsync and data enable never overlap. The exact lengths of each region, the mirrored coordinates and the polarity and emission combinations are shown only by the bench's sweeps. The same holds for the deferred switch from one profile to another. The bench compares every output on every clock against a model built from the requirements, using reduced profiles.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;
  localparam int CW = 11;

  typedef struct packed {
    logic [CW-1:0] act;
    logic [CW-1:0] fp;
    logic [CW-1:0] sw;
    logic [CW-1:0] bp;
  } axis_t;

  typedef struct packed {
    axis_t h;
    axis_t v;
  } prof_t;

  typedef enum logic [1:0] {FAM_SER, FAM_PAR, FAM_YUV, FAM_STRM} fam_e;

  localparam prof_t SER_DEF  = '{h: '{11'd320, 11'd359, 11'd1, 11'd241}, v: '{11'd240, 11'd4, 11'd1, 11'd17}};
  localparam prof_t PAR_DEF  = '{h: '{11'd320, 11'd38,  11'd1, 11'd50},  v: '{11'd240, 11'd4, 11'd1, 11'd17}};
  localparam prof_t YUV_DEF  = '{h: '{11'd640, 11'd252, 11'd1, 11'd28},  v: '{11'd320, 11'd4, 11'd1, 11'd18}};
  localparam prof_t STRM_DEF = '{h: '{11'd640, 11'd3,   11'd1, 11'd272}, v: '{11'd480, 11'd4, 11'd1, 11'd15}};

  function automatic logic code_ok(logic [3:0] c);
    return !(c == 4'd4 || c == 4'd9 || c >= 4'd12);
  endfunction

  function automatic fam_e code_fam(logic [3:0] c);
    case (c)
      4'd0, 4'd1, 4'd2, 4'd3: return FAM_SER;
      4'd5, 4'd6:             return FAM_PAR;
      4'd7, 4'd8:             return FAM_YUV;
      default:                return FAM_STRM;
    endcase
  endfunction
endpackage

// File: rtl/lcd_axis.sv
module lcd_axis import lcd_sync_pkg::*; (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  axis_t         cfg_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o,
  output logic          act_o,
  output logic          sync_o
);
  localparam int XW = CW + 2;

  logic [CW-1:0] cnt_q;
  logic [XW-1:0] cnt_x, tot, sync_lo, sync_hi;

  assign cnt_x   = {2'b00, cnt_q};
  assign sync_lo = {2'b00, cfg_i.act} + {2'b00, cfg_i.fp};
  assign sync_hi = sync_lo + {2'b00, cfg_i.sw};
  assign tot     = sync_hi + {2'b00, cfg_i.bp};

  assign last_o = (cnt_x == tot - XW'(1));
  assign act_o  = (cnt_q < cfg_i.act);
  assign sync_o = (cnt_x >= sync_lo) && (cnt_x < sync_hi);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step_i)  cnt_q <= last_o ? '0 : cnt_q + CW'(1);
  end

  // R2
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_x < tot);
endmodule

// File: rtl/lcd_fmt_sel.sv
module lcd_fmt_sel import lcd_sync_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] code_i,
  input  logic       bound_i,
  output logic       ok_o,
  output logic       run_o,
  output fam_e       fam_o
);
  logic run_q;
  fam_e fam_q;

  assign ok_o  = code_ok(code_i);
  assign run_o = run_q;
  assign fam_o = fam_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      fam_q <= FAM_SER;
    end else if (bound_i) begin
      run_q <= ok_o;
      if (ok_o) fam_q <= code_fam(code_i);
    end
  end
endmodule

// File: rtl/lcd_sig_out.sv
module lcd_sig_out import lcd_sync_pkg::*; (
  input  logic          run_i,
  input  logic [1:0]    act_i,
  input  logic [1:0]    sync_i,
  input  logic [CW-1:0] h_cnt_i,
  input  logic [CW-1:0] v_cnt_i,
  input  logic [CW-1:0] h_act_i,
  input  logic [CW-1:0] v_act_i,
  input  logic [1:0]    dir_i,
  input  logic [2:0]    pol_i,
  input  logic [1:0]    mode_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [CW-1:0] x_o,
  output logic [CW-1:0] y_o
);
  logic sync_en, de_en, hs_on, vs_on, de_on;

  assign sync_en = (mode_i == 2'd0) || (mode_i == 2'd1);
  assign de_en   = (mode_i == 2'd1) || (mode_i == 2'd2);

  assign hs_on = run_i & sync_en & sync_i[0];
  assign vs_on = run_i & sync_en & sync_i[1];
  assign de_on = run_i & de_en & act_i[0] & act_i[1];

  assign hsync_o = pol_i[0] ? hs_on : ~hs_on;
  assign vsync_o = pol_i[1] ? vs_on : ~vs_on;
  assign de_o    = pol_i[2] ? de_on : ~de_on;

  assign x_o = (run_i && act_i[0]) ? (dir_i[0] ? h_cnt_i : h_act_i - h_cnt_i - CW'(1)) : '0;
  assign y_o = (run_i && act_i[1]) ? (dir_i[1] ? v_cnt_i : v_act_i - v_cnt_i - CW'(1)) : '0;
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen import lcd_sync_pkg::*; #(
  parameter prof_t PROF_SER  = SER_DEF,
  parameter prof_t PROF_PAR  = PAR_DEF,
  parameter prof_t PROF_YUV  = YUV_DEF,
  parameter prof_t PROF_STRM = STRM_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    fmt_code_i,
  input  logic [1:0]    scan_dir_i,
  input  logic [2:0]    sync_pol_i,
  input  logic [1:0]    sync_mode_i,
  input  logic          line_inv_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          inv_o,
  output logic [CW-1:0] x_o,
  output logic [CW-1:0] y_o
);
  localparam int NAX = 2;
  localparam prof_t PROFS [4] = '{PROF_SER, PROF_PAR, PROF_YUV, PROF_STRM};

  logic          run_q, code_ok_w, frame_end, bound, inv_q;
  fam_e          fam_q;
  prof_t         cur;
  axis_t         ax_cfg  [NAX];
  logic [CW-1:0] ax_cnt  [NAX];
  logic [NAX-1:0] ax_step, ax_last, ax_act, ax_sync;

  lcd_fmt_sel u_fmt (
    .clk_i, .rst_ni, .code_i(fmt_code_i), .bound_i(bound),
    .ok_o(code_ok_w), .run_o(run_q), .fam_o(fam_q)
  );

  assign cur        = PROFS[fam_q];
  assign ax_cfg[0]  = cur.h;
  assign ax_cfg[1]  = cur.v;
  assign ax_step[0] = run_q;
  assign ax_step[1] = run_q & ax_last[0];
  assign frame_end  = run_q & ax_last[0] & ax_last[1];
  assign bound      = ~run_q | frame_end;

  for (genvar g = 0; g < NAX; g++) begin : g_axis
    lcd_axis u_axis (
      .clk_i, .rst_ni, .clr_i(bound), .step_i(ax_step[g]), .cfg_i(ax_cfg[g]),
      .cnt_o(ax_cnt[g]), .last_o(ax_last[g]), .act_o(ax_act[g]), .sync_o(ax_sync[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                                inv_q <= 1'b0;
    else if (bound && !code_ok_w)                               inv_q <= 1'b0;
    else if (run_q && ax_last[0] && (line_inv_i || ax_last[1])) inv_q <= ~inv_q;
  end
  assign inv_o = inv_q;

  lcd_sig_out u_out (
    .run_i(run_q), .act_i(ax_act), .sync_i(ax_sync),
    .h_cnt_i(ax_cnt[0]), .v_cnt_i(ax_cnt[1]),
    .h_act_i(cur.h.act), .v_act_i(cur.v.act),
    .dir_i(scan_dir_i), .pol_i(sync_pol_i), .mode_i(sync_mode_i),
    .hsync_o, .vsync_o, .de_o, .x_o, .y_o
  );

  // R11
  fmt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fam_q) |-> (ax_cnt[0] == '0 && ax_cnt[1] == '0));
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (x_o == '0 && y_o == '0 && !inv_o && ax_cnt[0] == '0 && ax_cnt[1] == '0));
  // R9
  inv_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(inv_o) |-> ax_cnt[0] == '0);
  // R9
  inv_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(inv_o) && !$past(line_inv_i)) |-> ax_cnt[1] == '0);
  // R5
  hs_de_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_mode_i == 2'd1 && hsync_o == sync_pol_i[0]) |-> de_o != sync_pol_i[2]);
endmodule

// File: tb/lcd_sync_gen_test.sv
module lcd_sync_gen_test;
  import lcd_sync_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_CYC   = 210;

  // reduced profiles: {h act,fp,sw,bp}, {v act,fp,sw,bp}
  localparam int T [4][2][4] = '{
    '{'{6,2,1,3}, '{4,1,1,2}},
    '{'{5,1,2,1}, '{3,2,1,1}},
    '{'{4,1,1,1}, '{2,1,1,1}},
    '{'{7,1,1,2}, '{5,1,2,1}}};

  function automatic prof_t mk(int f);
    prof_t p;
    p.h = '{CW'(T[f][0][0]), CW'(T[f][0][1]), CW'(T[f][0][2]), CW'(T[f][0][3])};
    p.v = '{CW'(T[f][1][0]), CW'(T[f][1][1]), CW'(T[f][1][2]), CW'(T[f][1][3])};
    return p;
  endfunction

  logic clk = 0, rst_n = 0;
  logic [3:0] code = 4'd2;
  logic [1:0] dir = 2'b11, mode = 2'd1;
  logic [2:0] pol = 3'b100;
  logic linv = 1'b1;
  logic hs, vs, de, inv;
  logic [CW-1:0] x, y;
  int checks = 0, fails = 0;
  bit done = 0, live = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_sync_gen #(.PROF_SER(mk(0)), .PROF_PAR(mk(1)), .PROF_YUV(mk(2)), .PROF_STRM(mk(3))) uut (
    .clk_i(clk), .rst_ni(rst_n), .fmt_code_i(code), .scan_dir_i(dir), .sync_pol_i(pol),
    .sync_mode_i(mode), .line_inv_i(linv), .hsync_o(hs), .vsync_o(vs), .de_o(de),
    .inv_o(inv), .x_o(x), .y_o(y));

  function automatic bit ok_c(int c); return !(c == 4 || c == 9 || c >= 12); endfunction
  function automatic int fam_c(int c);
    if (c <= 3) return 0;
    if (c <= 6) return 1;
    if (c <= 8) return 2;
    return 3;
  endfunction
  function automatic int tot(int f, int a); return T[f][a][0]+T[f][a][1]+T[f][a][2]+T[f][a][3]; endfunction

  // reference model
  int mh = 0, mv = 0, mf = 0;
  bit mrun = 0, minv = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mh <= 0; mv <= 0; mf <= 0; mrun <= 0; minv <= 0;
    end else begin
      bit hl, vl, bnd;
      hl  = mh == tot(mf, 0) - 1;
      vl  = mv == tot(mf, 1) - 1;
      bnd = !mrun || (hl && vl);
      if (bnd && !ok_c(code))            minv <= 0;
      else if (mrun && hl && (linv || vl)) minv <= !minv;
      if (bnd) begin
        mh <= 0; mv <= 0; mrun <= ok_c(code);
        if (ok_c(code)) mf <= fam_c(code);
      end else begin
        mh <= hl ? 0 : mh + 1;
        if (hl) mv <= mv + 1;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (code=%0d mode=%0d pol=%0d dir=%0d)",
               tag, act, exp, code, mode, pol, dir);
    end
  endtask

  task automatic cmp_all();
    bit sen, den, hon, von, don, ha, va;
    int ex, ey;
    sen = (mode == 0) || (mode == 1);
    den = (mode == 1) || (mode == 2);
    ha  = mh < T[mf][0][0];
    va  = mv < T[mf][1][0];
    hon = mrun && sen && mh >= T[mf][0][0]+T[mf][0][1] && mh < T[mf][0][0]+T[mf][0][1]+T[mf][0][2];
    von = mrun && sen && mv >= T[mf][1][0]+T[mf][1][1] && mv < T[mf][1][0]+T[mf][1][1]+T[mf][1][2];
    don = mrun && den && ha && va;
    ex  = (mrun && ha) ? (dir[0] ? mh : T[mf][0][0]-1-mh) : 0;
    ey  = (mrun && va) ? (dir[1] ? mv : T[mf][1][0]-1-mv) : 0;
    chk("hsync R3 R6 R2 R11", int'(hs), int'(pol[0] ? hon : !hon));
    chk("vsync R4 R6 R2 R11", int'(vs), int'(pol[1] ? von : !von));
    chk("de R5 R6 R10",       int'(de), int'(pol[2] ? don : !don));
    chk("x R7 R10",           int'(x), ex);
    chk("y R8 R10",           int'(y), ey);
    chk("inv R9 R10",         int'(inv), int'(minv));
  endtask

  always @(negedge clk) if (live) cmp_all();

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    step(3);
    // R1: reset state with de active-high, syncs active-low
    chk("reset hsync R1", int'(hs), 1);
    chk("reset vsync R1", int'(vs), 1);
    chk("reset de R1",    int'(de), 0);
    chk("reset x R1",     int'(x), 0);
    chk("reset y R1",     int'(y), 0);
    chk("reset inv R1",   int'(inv), 0);
    live = 1;
    rst_n = 1;
    step(WAIT_CYC);
    // R2 R6 R10 R11: every code under every emission mode, switched mid-frame
    for (int c = 0; c < 16; c++) begin
      for (int m = 0; m < 4; m++) begin
        code = 4'(c); mode = 2'(m);
        step(WAIT_CYC + 7 * c + m);
      end
    end
    // R3 R4 R5 R7 R8 R9: polarity, direction and inversion sweep on two profiles
    for (int c = 0; c < 2; c++) begin
      for (int d = 0; d < 4; d++) begin
        for (int p = 0; p < 8; p++) begin
          for (int l = 0; l < 2; l++) begin
            code = c ? 4'd11 : 4'd2; dir = 2'(d); pol = 3'(p); linv = l[0]; mode = 2'd1;
            step(WAIT_CYC / 2 + p);
          end
        end
      end
    end
    // R10: idle code held for a long stretch, then restart
    code = 4'd9; step(WAIT_CYC);
    chk("idle x R10", int'(x), 0);
    code = 4'd6; step(3);
    step(WAIT_CYC);
    live = 0;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule